// File: doc/BRIEF.md
# Static Memory Read Strobe Sequencer

This block runs one read access on an external static memory bus at a time. Each of eight chip-select lines has its own timing set, all counted in clock cycles: the read strobe gets a setup delay, a pulse length and a total access length, and the chip select gets its own setup delay and pulse length. The two strobe windows sit inside one shared access counter. The address and byte selects are driven for the whole access. The hold time after each strobe is whatever is left of the access.

A request carries a byte address and a chip-select index. The block accepts it only when idle or in the last cycle of the running access. It latches the timing of the chosen chip select and aligns the address to that device's data width. It then sequences the strobes, captures the 32-bit data bus on the edge that ends the read pulse, and returns the word together with a one-cycle done pulse in the final cycle of the access.

Top module: `smc_rd_timing`

## Requirements
- R1: Between accesses, and during and after reset, the read strobe, all eight chip selects and all byte selects are high, the address bus is zero, done is low, and a request is accepted only once reset has been released.
- R2: An access whose cycle field holds n lasts n clock cycles, starting on the clock after acceptance. Done is high only in the last of them. A field of 0 is treated as 1. While an access runs, req_ready stays low except in its done cycle.
- R3: The read strobe goes low after exactly rd_setup cycles of the access and stays low for rd_pulse consecutive cycles. A pulse of 0 leaves it high for the whole access.
- R4: Only the selected chip-select line goes low. It goes low after cs_setup cycles and stays low for cs_pulse cycles, independently of the read strobe.
- R5: When setup plus pulse exceeds the access length, the strobe concerned rises at the access boundary. Its hold is then zero cycles.
- R6: The address is aligned by the width code of the selected chip select: code 0 (8-bit) keeps every bit, code 1 (16-bit) forces bit 0 to zero, and codes 2 and 3 (32-bit) force bits 1 and 0 to zero.
- R7: Byte selects (active low, bit 0 = lane 0) are 1110 for width code 0, 1100 for code 1 and 0000 for codes 2 and 3. They and the address change only at the start and end of an access and are stable throughout it.
- R8: The data returned with done is the bus value present during the last low cycle of the read strobe. This also holds when that cycle is the done cycle. If the strobe never went low, the returned data is zero.
- R9: A request held valid during a done cycle is accepted at the end of that cycle, and its access starts on the next clock with no idle cycle in between.
- R10: The timing and width inputs are sampled only when a request is accepted. Changing them during an access does not alter that access.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_addr | input | 26 | Byte address of the read |
| req_cs | input | 3 | Chip-select index |
| cfg_rd_setup | input | 48 | Read-strobe setup per chip select, 6 bits each, CS0 in the low bits |
| cfg_rd_pulse | input | 48 | Read-strobe pulse length per chip select |
| cfg_rd_cycle | input | 48 | Access length per chip select |
| cfg_cs_setup | input | 48 | Chip-select setup per chip select |
| cfg_cs_pulse | input | 48 | Chip-select pulse length per chip select |
| cfg_width | input | 16 | Device width code per chip select, 2 bits each |
| mem_addr | output | 26 | External address bus |
| mem_nbs_n | output | 4 | Byte selects, active low |
| mem_ncs_n | output | 8 | Chip selects, active low |
| mem_nrd_n | output | 1 | Read strobe, active low |
| mem_data | input | 32 | External data bus |
| rd_done | output | 1 | High in the final cycle of an access |
| rd_data | output | 32 | Read word, valid while rd_done is high |

## Verification
Two events can share a single cycle. The first is the end of the read pulse, with its data capture, landing in the done cycle. The bench provokes this with a setup plus pulse that overruns the access length, and it checks that the returned word is the bus value of that last cycle and not a stale one. The second is the acceptance of the next request in a done cycle. The bench issues chained requests on different chip selects and compares the cycle in which each done appears against the acceptance cycle plus the access length, so any inserted idle cycle or early acceptance shows up as a timing mismatch.

// File: rtl/smc_rd_pkg.sv
package smc_rd_pkg;

  // device data width code, one per chip select
  typedef enum logic [1:0] {
    DW_8   = 2'd0,
    DW_16  = 2'd1,
    DW_32  = 2'd2,
    DW_32B = 2'd3
  } dev_width_e;

  localparam int NBS_W = 4;
  localparam int WCODE_W = 2;

endpackage

// File: rtl/smc_rd_addr_fmt.sv
module smc_rd_addr_fmt
  import smc_rd_pkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  logic [ADDR_W-1:0]  addr_in,
  input  logic [WCODE_W-1:0] width,
  output logic [ADDR_W-1:0]  addr_out,
  output logic [NBS_W-1:0]   nbs_n
);

  always_comb begin
    case (dev_width_e'(width))
      DW_8: begin
        addr_out = addr_in;
        nbs_n    = 4'b1110;
      end
      DW_16: begin
        addr_out = {addr_in[ADDR_W-1:1], 1'b0};
        nbs_n    = 4'b1100;
      end
      default: begin
        addr_out = {addr_in[ADDR_W-1:2], 2'b00};
        nbs_n    = 4'b0000;
      end
    endcase
  end

endmodule

// File: rtl/smc_rd_cfg_sel.sv
module smc_rd_cfg_sel
  import smc_rd_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int CNT_W  = 6,
  parameter int SEL_W  = 3
) (
  input  logic [SEL_W-1:0]          sel,
  input  logic [NUM_CS*CNT_W-1:0]   rd_setup_all,
  input  logic [NUM_CS*CNT_W-1:0]   rd_pulse_all,
  input  logic [NUM_CS*CNT_W-1:0]   rd_cycle_all,
  input  logic [NUM_CS*CNT_W-1:0]   cs_setup_all,
  input  logic [NUM_CS*CNT_W-1:0]   cs_pulse_all,
  input  logic [NUM_CS*WCODE_W-1:0] width_all,
  output logic [CNT_W-1:0]          rd_setup,
  output logic [CNT_W-1:0]          rd_pulse,
  output logic [CNT_W-1:0]          rd_cycle,
  output logic [CNT_W-1:0]          cs_setup,
  output logic [CNT_W-1:0]          cs_pulse,
  output logic [WCODE_W-1:0]        width
);

  logic [CNT_W-1:0]   rs_arr [NUM_CS];
  logic [CNT_W-1:0]   rp_arr [NUM_CS];
  logic [CNT_W-1:0]   rc_arr [NUM_CS];
  logic [CNT_W-1:0]   ss_arr [NUM_CS];
  logic [CNT_W-1:0]   sp_arr [NUM_CS];
  logic [WCODE_W-1:0] w_arr  [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_slice
    assign rs_arr[g] = rd_setup_all[g*CNT_W +: CNT_W];
    assign rp_arr[g] = rd_pulse_all[g*CNT_W +: CNT_W];
    assign rc_arr[g] = rd_cycle_all[g*CNT_W +: CNT_W];
    assign ss_arr[g] = cs_setup_all[g*CNT_W +: CNT_W];
    assign sp_arr[g] = cs_pulse_all[g*CNT_W +: CNT_W];
    assign w_arr[g]  = width_all[g*WCODE_W +: WCODE_W];
  end

  assign rd_setup = rs_arr[sel];
  assign rd_pulse = rp_arr[sel];
  assign rd_cycle = rc_arr[sel];
  assign cs_setup = ss_arr[sel];
  assign cs_pulse = sp_arr[sel];
  assign width    = w_arr[sel];

endmodule

// File: rtl/smc_rd_window.sv
module smc_rd_window #(
  parameter int CNT_W = 6
) (
  input  logic             busy,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] setup,
  input  logic [CNT_W-1:0] pulse,
  input  logic [CNT_W-1:0] span,
  output logic             active
);

  logic [CNT_W:0] sum;
  logic [CNT_W:0] stop;

  always_comb begin
    sum  = {1'b0, setup} + {1'b0, pulse};
    stop = (sum > {1'b0, span}) ? {1'b0, span} : sum;
    active = busy && ({1'b0, cnt} >= {1'b0, setup}) && ({1'b0, cnt} < stop);
  end

endmodule

// File: rtl/smc_rd_seq.sv
module smc_rd_seq #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] span_raw,
  output logic             busy,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] span,
  output logic             last
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] span_q, span_eff;

  assign span_eff = (span_raw == '0) ? ONE : span_raw;
  assign last     = busy_q && (cnt_q == span_q - ONE);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (last) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d  = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      span_q <= ONE;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      if (start) begin
        span_q <= span_eff;
      end
    end
  end

  assign busy = busy_q;
  assign cnt  = cnt_q;
  assign span = span_q;

endmodule

// File: rtl/smc_rd_timing.sv
module smc_rd_timing
  import smc_rd_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int CNT_W  = 6,
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32,
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [SEL_W-1:0]          req_cs,
  input  logic [NUM_CS*CNT_W-1:0]   cfg_rd_setup,
  input  logic [NUM_CS*CNT_W-1:0]   cfg_rd_pulse,
  input  logic [NUM_CS*CNT_W-1:0]   cfg_rd_cycle,
  input  logic [NUM_CS*CNT_W-1:0]   cfg_cs_setup,
  input  logic [NUM_CS*CNT_W-1:0]   cfg_cs_pulse,
  input  logic [NUM_CS*WCODE_W-1:0] cfg_width,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [NBS_W-1:0]          mem_nbs_n,
  output logic [NUM_CS-1:0]         mem_ncs_n,
  output logic                      mem_nrd_n,
  input  logic [DATA_W-1:0]         mem_data,
  output logic                      rd_done,
  output logic [DATA_W-1:0]         rd_data
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // selected timing set for the incoming request
  logic [CNT_W-1:0]   sel_rs, sel_rp, sel_rc, sel_ss, sel_sp;
  logic [WCODE_W-1:0] sel_w;
  logic [ADDR_W-1:0]  fmt_addr;
  logic [NBS_W-1:0]   fmt_nbs;

  smc_rd_cfg_sel #(
    .NUM_CS(NUM_CS), .CNT_W(CNT_W), .SEL_W(SEL_W)
  ) u_sel (
    .sel(req_cs),
    .rd_setup_all(cfg_rd_setup), .rd_pulse_all(cfg_rd_pulse),
    .rd_cycle_all(cfg_rd_cycle), .cs_setup_all(cfg_cs_setup),
    .cs_pulse_all(cfg_cs_pulse), .width_all(cfg_width),
    .rd_setup(sel_rs), .rd_pulse(sel_rp), .rd_cycle(sel_rc),
    .cs_setup(sel_ss), .cs_pulse(sel_sp), .width(sel_w)
  );

  smc_rd_addr_fmt #(.ADDR_W(ADDR_W)) u_fmt (
    .addr_in(req_addr), .width(sel_w),
    .addr_out(fmt_addr), .nbs_n(fmt_nbs)
  );

  // access sequencer
  logic             start, busy, last;
  logic [CNT_W-1:0] cnt, span;

  assign req_ready = rst_sync_q && (!busy || last);
  assign start     = req_valid && req_ready;

  smc_rd_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_q), .start(start), .span_raw(sel_rc),
    .busy(busy), .cnt(cnt), .span(span), .last(last)
  );

  // per-access latched state, enabled by start
  logic [SEL_W-1:0]  cs_q;
  logic [ADDR_W-1:0] addr_q;
  logic [NBS_W-1:0]  nbs_q;
  logic [CNT_W-1:0]  rs_q, rp_q, ss_q, sp_q;

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      cs_q   <= '0;
      addr_q <= '0;
      nbs_q  <= '1;
      rs_q   <= '0;
      rp_q   <= '0;
      ss_q   <= '0;
      sp_q   <= '0;
    end else if (start) begin
      cs_q   <= req_cs;
      addr_q <= fmt_addr;
      nbs_q  <= fmt_nbs;
      rs_q   <= sel_rs;
      rp_q   <= sel_rp;
      ss_q   <= sel_ss;
      sp_q   <= sel_sp;
    end
  end

  // strobe windows: read strobe now and one count ahead, chip select now
  logic             rd_act, rd_act_nx, cs_act, rd_close;
  logic [CNT_W-1:0] cnt_nx;

  assign cnt_nx = cnt + ONE;

  smc_rd_window #(.CNT_W(CNT_W)) u_win_rd (
    .busy(busy), .cnt(cnt), .setup(rs_q), .pulse(rp_q), .span(span),
    .active(rd_act)
  );

  smc_rd_window #(.CNT_W(CNT_W)) u_win_rd_nx (
    .busy(busy), .cnt(cnt_nx), .setup(rs_q), .pulse(rp_q), .span(span),
    .active(rd_act_nx)
  );

  smc_rd_window #(.CNT_W(CNT_W)) u_win_cs (
    .busy(busy), .cnt(cnt), .setup(ss_q), .pulse(sp_q), .span(span),
    .active(cs_act)
  );

  // the read strobe rises at the coming edge
  assign rd_close = rd_act && (last || !rd_act_nx);

  // pins
  assign mem_addr  = busy ? addr_q : '0;
  assign mem_nbs_n = busy ? nbs_q : '1;
  assign mem_nrd_n = !rd_act;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_ncs
    assign mem_ncs_n[g] = !(cs_act && (cs_q == SEL_W'(g)));
  end

  // data capture at the rising edge of the read strobe
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    data_d = data_q;
    if (start) begin
      data_d = '0;
    end else if (rd_close) begin
      data_d = mem_data;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      data_q <= '0;
    end else begin
      data_q <= data_d;
    end
  end

  assign rd_done = last;
  assign rd_data = rd_close ? mem_data : data_q;

endmodule

// File: rtl/smc_rd_timing_chk.sv
module smc_rd_timing_chk #(
  parameter int NUM_CS = 8,
  parameter int CNT_W  = 6,
  parameter int ADDR_W = 26,
  parameter int SEL_W  = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic [SEL_W-1:0]        req_cs,
  input logic [NUM_CS*CNT_W-1:0] cfg_rd_cycle,
  input logic [ADDR_W-1:0]       mem_addr,
  input logic [3:0]              mem_nbs_n,
  input logic [NUM_CS-1:0]       mem_ncs_n,
  input logic                    mem_nrd_n,
  input logic                    rd_done,
  input logic                    busy,
  input logic                    last
);

  // independent access-length tracker
  logic [CNT_W:0]   run_cnt, run_len;
  logic [CNT_W-1:0] raw_len;

  assign raw_len = cfg_rd_cycle[req_cs*CNT_W +: CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      run_len <= '0;
    end else if (req_valid && req_ready) begin
      run_cnt <= '0;
      run_len <= (raw_len == '0) ? (CNT_W+1)'(1) : {1'b0, raw_len};
    end else if (busy) begin
      run_cnt <= run_cnt + (CNT_W+1)'(1);
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_nrd_n && (&mem_ncs_n) && (&mem_nbs_n) && (mem_addr == '0) && !rd_done));

  p_done_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> (run_cnt + (CNT_W+1)'(1) == run_len));

  p_strobe_in_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_nrd_n |-> (mem_nbs_n != 4'hF));

  p_single_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_ncs_n));

  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> ($stable(mem_addr) && $stable(mem_nbs_n)));

endmodule

bind smc_rd_timing smc_rd_timing_chk #(
  .NUM_CS(NUM_CS), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_cs(req_cs), .cfg_rd_cycle(cfg_rd_cycle), .mem_addr(mem_addr),
  .mem_nbs_n(mem_nbs_n), .mem_ncs_n(mem_ncs_n), .mem_nrd_n(mem_nrd_n),
  .rd_done(rd_done), .busy(busy), .last(last)
);

// File: tb/sim_smc_rd_timing.sv
`timescale 1ns/1ps
module sim_smc_rd_timing;

  localparam int NUM_CS = 8;
  localparam int CNT_W  = 6;
  localparam int ADDR_W = 26;
  localparam int DATA_W = 32;
  localparam int SEL_W  = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                    rst_n;
  logic                    req_valid, req_ready;
  logic [ADDR_W-1:0]       req_addr;
  logic [SEL_W-1:0]        req_cs;
  logic [NUM_CS*CNT_W-1:0] cfg_rd_setup, cfg_rd_pulse, cfg_rd_cycle;
  logic [NUM_CS*CNT_W-1:0] cfg_cs_setup, cfg_cs_pulse;
  logic [NUM_CS*2-1:0]     cfg_width;
  logic [ADDR_W-1:0]       mem_addr;
  logic [3:0]              mem_nbs_n;
  logic [NUM_CS-1:0]       mem_ncs_n;
  logic                    mem_nrd_n;
  logic [DATA_W-1:0]       mem_data;
  logic                    rd_done;
  logic [DATA_W-1:0]       rd_data;

  int t_rs [NUM_CS];
  int t_rp [NUM_CS];
  int t_rc [NUM_CS];
  int t_ss [NUM_CS];
  int t_sp [NUM_CS];
  int t_w  [NUM_CS];

  always_comb begin
    for (int i = 0; i < NUM_CS; i++) begin
      cfg_rd_setup[i*CNT_W +: CNT_W] = CNT_W'(t_rs[i]);
      cfg_rd_pulse[i*CNT_W +: CNT_W] = CNT_W'(t_rp[i]);
      cfg_rd_cycle[i*CNT_W +: CNT_W] = CNT_W'(t_rc[i]);
      cfg_cs_setup[i*CNT_W +: CNT_W] = CNT_W'(t_ss[i]);
      cfg_cs_pulse[i*CNT_W +: CNT_W] = CNT_W'(t_sp[i]);
      cfg_width[i*2 +: 2]            = 2'(t_w[i]);
    end
  end

  function automatic logic [DATA_W-1:0] pat(logic [ADDR_W-1:0] a);
    return {a[15:0] ^ 16'h5A3C, a[25:10]};
  endfunction

  // memory model: drives data only while the read strobe is low
  assign mem_data = !mem_nrd_n ? pat(mem_addr) : 32'h0BAD_F00D;

  smc_rd_timing #(
    .NUM_CS(NUM_CS), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_cs(req_cs),
    .cfg_rd_setup(cfg_rd_setup), .cfg_rd_pulse(cfg_rd_pulse),
    .cfg_rd_cycle(cfg_rd_cycle), .cfg_cs_setup(cfg_cs_setup),
    .cfg_cs_pulse(cfg_cs_pulse), .cfg_width(cfg_width),
    .mem_addr(mem_addr), .mem_nbs_n(mem_nbs_n), .mem_ncs_n(mem_ncs_n),
    .mem_nrd_n(mem_nrd_n), .mem_data(mem_data),
    .rd_done(rd_done), .rd_data(rd_data)
  );

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [3:0]        nbs;
    int                cs;
    int                rd_first, rd_len, cs_first, cs_len;
    logic [DATA_W-1:0] data;
    int                done_at;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   gcyc  = 0;
  bit   mon_on = 1'b0;

  always @(posedge clk) gcyc <= gcyc + 1;

  task automatic chk(string tag, longint got, longint expv);
    n_cmp++;
    if (got != expv) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, expv);
    end
  endtask

  // driver: presents a request, pushes its expected outcome at acceptance
  task automatic issue(int cs, logic [ADDR_W-1:0] a);
    exp_t e;
    int span, stop;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_cs    = SEL_W'(cs);
    while (!req_ready) @(negedge clk);
    span = (t_rc[cs] == 0) ? 1 : t_rc[cs];
    stop = (t_rs[cs] + t_rp[cs] > span) ? span : t_rs[cs] + t_rp[cs];
    e.rd_len   = (stop > t_rs[cs]) ? stop - t_rs[cs] : 0;
    e.rd_first = (e.rd_len > 0) ? t_rs[cs] : -1;
    stop = (t_ss[cs] + t_sp[cs] > span) ? span : t_ss[cs] + t_sp[cs];
    e.cs_len   = (stop > t_ss[cs]) ? stop - t_ss[cs] : 0;
    e.cs_first = (e.cs_len > 0) ? t_ss[cs] : -1;
    e.cs       = cs;
    case (t_w[cs])
      0:       begin e.addr = a;                           e.nbs = 4'b1110; end
      1:       begin e.addr = {a[ADDR_W-1:1], 1'b0};       e.nbs = 4'b1100; end
      default: begin e.addr = {a[ADDR_W-1:2], 2'b00};      e.nbs = 4'b0000; end
    endcase
    e.data    = (e.rd_len > 0) ? pat(e.addr) : '0;
    e.done_at = gcyc + span;
    exp_q.push_back(e);
    @(posedge clk);
  endtask

  task automatic single(int cs, logic [ADDR_W-1:0] a);
    issue(cs, a);
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_cfg(int cs, int rs, int rp, int rc, int ss, int sp, int w);
    t_rs[cs] = rs; t_rp[cs] = rp; t_rc[cs] = rc;
    t_ss[cs] = ss; t_sp[cs] = sp; t_w[cs]  = w;
  endtask

  // monitor: observes the bus and compares against the scoreboard
  int idx = 0, m_rd_first = -1, m_rd_len = 0, m_cs_first = -1, m_cs_len = 0;
  int other_bad = 0, stab_bad = 0;
  logic [ADDR_W-1:0] addr0;
  logic [3:0]        nbs0;

  always @(negedge clk) begin
    exp_t cur;
    if (mon_on) begin
      if (mem_nbs_n != 4'hF) begin
        if (exp_q.size() == 0) begin
          chk("R2 access without accepted request", 1, 0);
        end else begin
          cur = exp_q[0];
          if (idx == 0) begin
            addr0 = mem_addr;
            nbs0  = mem_nbs_n;
          end else if (mem_addr != addr0 || mem_nbs_n != nbs0) begin
            stab_bad++;
          end
          if (!mem_nrd_n) begin
            if (m_rd_first < 0) m_rd_first = idx;
            m_rd_len++;
          end
          for (int i = 0; i < NUM_CS; i++) begin
            if (!mem_ncs_n[i]) begin
              if (i == cur.cs) begin
                if (m_cs_first < 0) m_cs_first = idx;
                m_cs_len++;
              end else begin
                other_bad++;
              end
            end
          end
          idx++;
          if (rd_done) begin
            void'(exp_q.pop_front());
            chk("R2/R9 done cycle", gcyc, cur.done_at);
            chk("R6 address alignment", mem_addr, cur.addr);
            chk("R7 byte selects", nbs0, cur.nbs);
            chk("R7 address and byte selects stable", stab_bad, 0);
            chk("R3/R5 read strobe fall", m_rd_first, cur.rd_first);
            chk("R3/R5 read strobe length", m_rd_len, cur.rd_len);
            chk("R4 chip select fall", m_cs_first, cur.cs_first);
            chk("R4 chip select length", m_cs_len, cur.cs_len);
            chk("R4 unselected lines high", other_bad, 0);
            chk("R8 read data", rd_data, cur.data);
            idx = 0; m_rd_first = -1; m_rd_len = 0;
            m_cs_first = -1; m_cs_len = 0; other_bad = 0; stab_bad = 0;
          end
        end
      end else begin
        if (rd_done) chk("R1 done while idle", 1, 0);
        if (!mem_nrd_n || mem_ncs_n != '1 || mem_addr != '0)
          chk("R1 bus quiet while idle", 1, 0);
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog expired: got hang expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    req_cs    = '0;
    for (int i = 0; i < NUM_CS; i++) set_cfg(i, 1, 2, 5, 0, 5, 2);
    set_cfg(2, 2, 3, 8, 1, 5, 2);
    set_cfg(0, 0, 1, 2, 0, 2, 0);
    set_cfg(7, 3, 9, 6, 4, 10, 1);
    set_cfg(3, 1, 0, 4, 0, 4, 3);
    set_cfg(4, 0, 1, 0, 0, 1, 2);
    set_cfg(1, 1, 3, 7, 2, 3, 1);

    // R1: state during and after reset
    repeat (3) @(negedge clk);
    chk("R1 ready low in reset", req_ready, 0);
    chk("R1 read strobe high in reset", mem_nrd_n, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ready after reset", req_ready, 1);
    chk("R1 chip selects high", mem_ncs_n, 8'hFF);
    chk("R1 byte selects high", mem_nbs_n, 4'hF);
    chk("R1 address zero", mem_addr, 0);
    chk("R1 done low", rd_done, 0);
    mon_on = 1'b1;

    // R3 R4 R6 R7 R8: 32-bit device, separate windows
    single(2, 26'h123_4567);
    // R6 R7: 8-bit device, odd address, shortest pulse
    single(0, 26'h0AB_CDEF);
    // R5 R8: both strobes overrun the cycle, capture in done cycle
    single(7, 26'h2FF_FFFF);
    // R3 R8: zero pulse, data returned as zero; width code 3
    single(3, 26'h155_5557);
    // R2: cycle field zero acts as one
    single(4, 26'h000_0013);

    // R9: chained requests, no idle cycle between them
    issue(2, 26'h010_2031);
    issue(0, 26'h020_3041);
    issue(4, 26'h030_4051);
    issue(7, 26'h040_5061);
    issue(4, 26'h050_6071);
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);

    // R10: configuration changed during an access has no effect on it
    issue(1, 26'h3AA_AAA9);
    @(negedge clk);
    req_valid = 1'b0;
    set_cfg(1, 0, 1, 3, 0, 1, 0);
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    // R10: new values apply to the next access
    single(1, 26'h3AA_AAA9);

    repeat (4) @(negedge clk);
    chk("R2 scoreboard drained", exp_q.size(), 0);
    chk("R1 idle after traffic", mem_nrd_n, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule